// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the flag register of a small 8-bit microcontroller core. It holds four arithmetic flags: carry, half-carry, zero and overflow. It also holds two power-management flags: power-down and watchdog time-out.

The arithmetic flags are derived inside the block from the operands and the result that the ALU presents each cycle. A rotate-through-carry operation loads only the carry flag. A software write at the register's address replaces the arithmetic flags. The two power flags ignore software writes and follow only power-up, halt, clear-watchdog and watchdog time-out events.

The register is read combinationally through a register-file read port at a fixed address. It is also presented directly to the core on a flag bus. Nothing saves or restores it on calls or interrupts; software must do that when it matters.

Top module: `status_flag_reg`

## Requirements
- R1: The register bits are carry at bit 0, half-carry at bit 1, zero at bit 2, overflow at bit 3, power-down at bit 4 and time-out at bit 5. Bits 6 and 7 always read 0. `rd_data` returns the register when `rd_addr` equals `STAT_ADDR` and 0 otherwise.
- R2: For `alu_op` = 1 (add), carry takes the carry out of the most significant bit. For `alu_op` = 2 (subtract), carry is 1 when no borrow occurs and 0 when one does.
- R3: Half-carry is 1 on a carry out of bits 3:0 in an add, and on no borrow from bit 4 into bits 3:0 in a subtract. Otherwise it is 0.
- R4: For add, subtract and `alu_op` = 3 (logic), zero is 1 exactly when `alu_res` is 0.
- R5: For add and subtract, overflow is 1 exactly when the carry into the most significant bit differs from the carry out of it.
- R6: A logic operation leaves carry, half-carry and overflow unchanged. `alu_op` = 4 (rotate through carry) loads carry from `rot_bit` and leaves the other flags unchanged. `alu_op` = 0 changes nothing.
- R7: A write with `wr_en` high and `wr_addr` equal to `STAT_ADDR` loads bits 3:0 from `wr_data[3:0]`, overriding any ALU update in the same cycle. It leaves power-down and time-out unchanged. A write at any other address has no effect.
- R8: Power-down is 0 after power-up reset. It is cleared by `clr_wdt` and set by `halt`. When both strobes arrive together, `halt` wins.
- R9: Time-out is 0 after power-up reset. It is cleared by `clr_wdt` or `halt` and set by `wdt_tmo`. `wdt_tmo` wins over either clearing strobe.
- R10: While `rst_n` is low, every bit of the register is 0.
- R11: With no operation, no write to the register and no event strobe, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-up reset |
| alu_op | input | 3 | Operation class this cycle: 0 none, 1 add, 2 subtract, 3 logic, 4 rotate through carry |
| alu_a | input | DATA_W | First ALU operand |
| alu_b | input | DATA_W | Second ALU operand (subtrahend for subtract) |
| alu_res | input | DATA_W | ALU result |
| rot_bit | input | 1 | Bit shifted out by a rotate through carry |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | ADDR_W | Register-file write address |
| wr_data | input | 8 | Register-file write data |
| clr_wdt | input | 1 | Clear-watchdog instruction executed |
| halt | input | 1 | Halt instruction executed |
| wdt_tmo | input | 1 | Watchdog time-out event |
| rd_addr | input | ADDR_W | Register-file read address |
| rd_data | output | 8 | Read data, the register or 0 |
| flags_o | output | 8 | Register contents, always visible |

## Verification
The assertions take for granted that `alu_op` carries only the codes 0 to 4. They also assume that `alu_a`, `alu_b` and `alu_res` are consistent with each other, meaning the result is a true sum, or a true difference, of the operands modulo 256. This matters because the carries are recovered from the three buses. Every stimulus vector is therefore built from a genuine 8-bit addition or subtraction, and operand values are driven only when the operation code names an arithmetic class. Event strobes are single-cycle pulses, including the simultaneous combinations whose priority is defined.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ADD   = 3'd1,
        OP_SUB   = 3'd2,
        OP_LOGIC = 3'd3,
        OP_ROTC  = 3'd4
    } alu_op_e;

    // Arithmetic flags, most significant first: overflow, zero, half-carry, carry
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } arith_t;

    // Full six-bit register image: time-out at bit 5 down to carry at bit 0
    typedef struct packed {
        logic   to;
        logic   pd;
        arith_t ar;
    } status_t;

    localparam int REG_W = 8;

endpackage

// File: rtl/sflag_arith.sv
module sflag_arith
    import sflag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e             op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   res,
    input  logic                rot_bit,
    input  arith_t              cur,
    output arith_t              nxt
);

    localparam int MSB = DATA_W - 1;
    localparam int NIB = 4;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] carry_in_v;
    logic              msb_cout;
    logic              carry_unused;

    // For subtraction the adder sees the inverted subtrahend; its carries are no-borrow signals.
    assign b_eff        = (op == OP_SUB) ? ~b : b;
    assign carry_in_v   = a ^ b_eff ^ res;
    assign msb_cout     = (a[MSB] & b_eff[MSB]) | (carry_in_v[MSB] & (a[MSB] ^ b_eff[MSB]));
    assign carry_unused = ^carry_in_v;

    always_comb begin
        nxt = cur;
        unique case (op)
            OP_ADD, OP_SUB: begin
                nxt.c  = msb_cout;
                nxt.ac = carry_in_v[NIB];
                nxt.z  = (res == '0);
                nxt.ov = carry_in_v[MSB] ^ msb_cout;
            end
            OP_LOGIC: begin
                nxt.z  = (res == '0);
            end
            OP_ROTC: begin
                nxt.c  = rot_bit;
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/sflag_power.sv
module sflag_power (
    input  logic pd_q,
    input  logic to_q,
    input  logic clr_wdt,
    input  logic halt,
    input  logic wdt_tmo,
    output logic pd_d,
    output logic to_d
);

    always_comb begin
        pd_d = pd_q;
        if (halt) begin
            pd_d = 1'b1;
        end else if (clr_wdt) begin
            pd_d = 1'b0;
        end

        to_d = to_q;
        if (wdt_tmo) begin
            to_d = 1'b1;
        end else if (clr_wdt || halt) begin
            to_d = 1'b0;
        end
    end

endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import sflag_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h0A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          alu_op,
    input  logic [DATA_W-1:0]   alu_a,
    input  logic [DATA_W-1:0]   alu_b,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic                rot_bit,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                clr_wdt,
    input  logic                halt,
    input  logic                wdt_tmo,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    output logic [REG_W-1:0]    flags_o
);

    localparam int ST_W  = $bits(status_t);
    localparam int PAD_W = REG_W - ST_W;

    status_t st_d;
    status_t st_q;
    arith_t  ar_alu;
    logic    pd_evt;
    logic    to_evt;
    logic    wr_hit;
    logic [REG_W-1:0] wr_unused;

    assign wr_hit    = wr_en && (wr_addr == STAT_ADDR);
    assign wr_unused = wr_data;

    sflag_arith #(
        .DATA_W (DATA_W)
    ) u_arith (
        .op      (alu_op_e'(alu_op)),
        .a       (alu_a),
        .b       (alu_b),
        .res     (alu_res),
        .rot_bit (rot_bit),
        .cur     (st_q.ar),
        .nxt     (ar_alu)
    );

    sflag_power u_power (
        .pd_q    (st_q.pd),
        .to_q    (st_q.to),
        .clr_wdt (clr_wdt),
        .halt    (halt),
        .wdt_tmo (wdt_tmo),
        .pd_d    (pd_evt),
        .to_d    (to_evt)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ar = wr_hit ? arith_t'(wr_data[$bits(arith_t)-1:0]) : ar_alu;
        st_d.pd = pd_evt;
        st_d.to = to_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = {{PAD_W{1'b0}}, st_q};
    assign rd_data = (rd_addr == STAT_ADDR) ? flags_o : '0;

endmodule

// File: rtl/status_flag_reg_chk.sv
module status_flag_reg_chk
    import sflag_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 7'h0A
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          alu_op,
    input  logic [DATA_W-1:0]   alu_a,
    input  logic [DATA_W-1:0]   alu_b,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic                rot_bit,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic                clr_wdt,
    input  logic                halt,
    input  logic                wdt_tmo,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [REG_W-1:0]    rd_data,
    input  logic [REG_W-1:0]    flags_o
);

    localparam int MSB = DATA_W - 1;

    logic hit;
    logic quiet;
    assign hit   = wr_en && (wr_addr == STAT_ADDR);
    assign quiet = (alu_op == 3'd0) && !hit && !clr_wdt && !halt && !wdt_tmo;

    // R1
    hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[7:6] == 2'b00);

    // R1
    rd_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr != STAT_ADDR) |-> (rd_data == '0));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && (alu_op == 3'd1 || alu_op == 3'd2 || alu_op == 3'd3))
        |=> (flags_o[2] == ($past(alu_res) == '0)));

    // R5
    add_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && alu_op == 3'd1 && alu_a[MSB] == alu_b[MSB] && alu_res[MSB] != alu_a[MSB])
        |=> flags_o[3]);

    // R6
    logic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && alu_op == 3'd3) |=> ($stable(flags_o[3]) && $stable(flags_o[1:0])));

    // R6
    rot_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && alu_op == 3'd4) |=> (flags_o[0] == $past(rot_bit) && $stable(flags_o[3:1])));

    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (flags_o[3:0] == $past(wr_data[3:0])));

    // R7
    wr_keep_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr_wdt && !halt && !wdt_tmo) |=> $stable(flags_o[5:4]));

    // R8
    halt_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> flags_o[4]);

    // R8
    clr_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt && !halt) |=> !flags_o[4]);

    // R9
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo |=> flags_o[5]);

    // R9
    to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_wdt || halt) && !wdt_tmo) |=> !flags_o[5]);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(flags_o));

endmodule

bind status_flag_reg status_flag_reg_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .STAT_ADDR (STAT_ADDR)
) u_chk (.*);

// File: tb/test_status_flag_reg.sv
`timescale 1ns/1ps
module test_status_flag_reg;

    localparam int          DATA_W = 8;
    localparam int          ADDR_W = 7;
    localparam logic [6:0]  SADDR  = 7'h0A;

    // {op[2:0], a[7:0], b[7:0], res[7:0], expected {OV,Z,AC,C}}
    localparam int NV = 10;
    localparam logic [30:0] VEC [NV] = '{
        {3'd1, 8'h00, 8'h00, 8'h00, 4'h4},
        {3'd1, 8'h0F, 8'h01, 8'h10, 4'h2},
        {3'd1, 8'h7F, 8'h01, 8'h80, 4'hA},
        {3'd1, 8'hFF, 8'h01, 8'h00, 4'h7},
        {3'd1, 8'h80, 8'h80, 8'h00, 4'hD},
        {3'd2, 8'h05, 8'h03, 8'h02, 4'h3},
        {3'd2, 8'h03, 8'h05, 8'hFE, 4'h0},
        {3'd2, 8'h10, 8'h01, 8'h0F, 4'h1},
        {3'd2, 8'h80, 8'h01, 8'h7F, 4'h9},
        {3'd2, 8'h42, 8'h42, 8'h00, 4'h7}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        alu_op = '0;
    logic [DATA_W-1:0] alu_a = '0;
    logic [DATA_W-1:0] alu_b = '0;
    logic [DATA_W-1:0] alu_res = '0;
    logic              rot_bit = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              clr_wdt = 1'b0;
    logic              halt = 1'b0;
    logic              wdt_tmo = 1'b0;
    logic [ADDR_W-1:0] rd_addr = SADDR;
    logic [7:0]        rd_data;
    logic [7:0]        flags_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    status_flag_reg #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (SADDR)
    ) i_status_flag_reg (
        .clk, .rst_n, .alu_op, .alu_a, .alu_b, .alu_res, .rot_bit,
        .wr_en, .wr_addr, .wr_data, .clr_wdt, .halt, .wdt_tmo,
        .rd_addr, .rd_data, .flags_o
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_op  = 3'd0;
        alu_a   = '0;
        alu_b   = '0;
        alu_res = '0;
        rot_bit = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        clr_wdt = 1'b0;
        halt    = 1'b0;
        wdt_tmo = 1'b0;
    endtask

    // Inputs are already driven at a falling edge; let one rising edge pass, then clear them.
    task automatic step();
        @(negedge clk);
        idle_inputs();
        #0.5;
    endtask

    task automatic do_write(input logic [6:0] addr, input logic [7:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        step();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R10 in reset", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", rd_data, 8'h00);

        for (int i = 0; i < NV; i++) begin
            alu_op  = VEC[i][30:28];
            alu_a   = VEC[i][27:20];
            alu_b   = VEC[i][19:12];
            alu_res = VEC[i][11:4];
            step();
            check($sformatf("R2/R3/R4/R5 vector %0d", i), rd_data, {4'h0, VEC[i][3:0]});
        end

        // R6: logic touches zero only (state is 07 here)
        alu_op = 3'd3; alu_res = 8'h01; step();
        check("R6 logic nonzero keeps C/AC/OV", rd_data, 8'h03);
        alu_op = 3'd3; alu_res = 8'h00; step();
        check("R4 logic zero result", rd_data, 8'h07);
        alu_op = 3'd4; rot_bit = 1'b0; step();
        check("R6 rotate loads 0", rd_data, 8'h06);
        alu_op = 3'd4; rot_bit = 1'b1; step();
        check("R6 rotate loads 1", rd_data, 8'h07);

        // R1: read decode
        rd_addr = SADDR + 7'd1; #0.5;
        check("R1 other address reads 0", rd_data, 8'h00);
        rd_addr = SADDR; #0.5;

        halt = 1'b1; step();
        check("R8 halt sets PD", rd_data, 8'h17);
        wdt_tmo = 1'b1; step();
        check("R9 time-out sets TO", rd_data, 8'h37);
        do_write(SADDR, 8'hFF);
        check("R7/R1 write ones keeps PD/TO, bits 7:6 zero", rd_data, 8'h3F);
        do_write(SADDR, 8'h00);
        check("R7 write zeros keeps PD/TO", rd_data, 8'h30);
        alu_op = 3'd1; alu_a = 8'h00; alu_b = 8'h00; alu_res = 8'h00;
        do_write(SADDR, 8'h05);
        check("R7 write beats ALU", rd_data, 8'h35);
        do_write(SADDR + 7'd1, 8'h0F);
        check("R7 write elsewhere ignored", rd_data, 8'h35);
        step();
        check("R11 idle holds", rd_data, 8'h35);
        clr_wdt = 1'b1; step();
        check("R8/R9 clear-watchdog clears PD and TO", rd_data, 8'h05);
        wdt_tmo = 1'b1; halt = 1'b1; step();
        check("R9 time-out beats halt", rd_data, 8'h35);
        wdt_tmo = 1'b1; clr_wdt = 1'b1; step();
        check("R9 time-out beats clear-watchdog", rd_data, 8'h25);
        halt = 1'b1; clr_wdt = 1'b1; step();
        check("R8 halt beats clear-watchdog", rd_data, 8'h15);
        halt = 1'b1; step();
        check("R9 halt clears TO", rd_data, 8'h15);

        rst_n = 1'b0; #1;
        check("R10 reset clears all", flags_o, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule